// File: doc/BRIEF.md
# Serial Controller Status Flags

This block keeps the status word of a four-line serial flash controller. It takes command strobes (enable and disable), register-bus strobes (status read, transmit-data write, receive-data read), event pulses from the serializer (holding data moved into the shifter, receive register loaded, instruction finished) and two levels: shifter busy and the chip-select pin. From these it builds eight status flags and presents them as one 32-bit read-only word and as separate signals.

Three of the flags are sticky: instruction finished, chip-select rise and receive overrun. Each latches on its event and clears when the status word is read. If an event and a read fall in the same cycle, the flag stays set so the event is not lost. The transmitter-idle flag waits for a programmable transfer delay, counted in clock cycles, which is reloaded each time the shifter goes idle.

All flags are registered. An input that is sampled at a clock edge shows up on the outputs right after that edge. A status read returns the value from before the edge, and the clearing takes effect at the edge.

Top module: `sctl_status`

## Requirements
- R1: The status word has the following layout: bit 24 enabled, bit 10 instruction finished, bit 9 chip-select level, bit 8 chip-select rise, bit 3 overrun, bit 2 transmitter idle, bit 1 transmit holding empty, bit 0 receive full. Every other bit reads 0. Each per-flag output equals its bit.
- R2: While reset is asserted, and right after it, the whole status word is 0.
- R3: The instruction-finished flag sets on `instr_done`. The chip-select-rise flag sets when `cs_n` is 1 while the stored level is 0. Both clear at a status read, and a set in the same cycle as the read wins.
- R4: Overrun sets when `rx_load` arrives while receive-full is 1 and `rx_rd` is 0. It is sticky and clears at a status read. A load that comes together with a receive read is not an overrun.
- R5: Bit 9 shows the `cs_n` level sampled at the previous edge: 1 means deasserted, 0 means asserted.
- R6: The enabled flag sets on `cmd_enable` and clears on `cmd_disable`. When both arrive in the same cycle, disable wins.
- R7: Transmit-holding-empty is 0 whenever the controller is disabled. It sets on enable and clears on `tx_wr`. It sets again on `tx_to_shift` while enabled, and `tx_wr` wins over a same-cycle move.
- R8: `tx_wr` clears transmitter-idle. It sets again only when holding-empty is 1, `shift_busy` is 0 and the transfer delay has run out. For a delay of D > 0, it sets D cycles later than it would for a delay of 0, counted from the cycle in which `shift_busy` falls.
- R9: Receive-full sets on `rx_load` and clears on `rx_rd`. A load wins over a same-cycle read.
- R10: With a delay of 0, transmitter-idle sets at the same edge that samples `shift_busy` falling, provided holding-empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_enable | input | 1 | Enable command pulse |
| cmd_disable | input | 1 | Disable command pulse |
| stat_rd | input | 1 | Status word read strobe |
| tx_wr | input | 1 | Transmit data register write strobe |
| rx_rd | input | 1 | Receive data register read strobe |
| tx_to_shift | input | 1 | Holding data moved into the shifter |
| shift_busy | input | 1 | Shifter holds data (level) |
| rx_load | input | 1 | Serializer loaded the receive register |
| instr_done | input | 1 | Instruction finished pulse |
| cs_n | input | 1 | Chip-select pin level, 1 = deasserted |
| xfer_dly | input | DLY_W | Transfer delay in clock cycles |
| status_word | output | 32 | Assembled status word |
| en_sts | output | 1 | Controller enabled |
| instr_end | output | 1 | Sticky instruction finished |
| cs_high | output | 1 | Chip-select level |
| cs_rise | output | 1 | Sticky chip-select rise |
| ovr_err | output | 1 | Sticky receive overrun |
| tx_empty | output | 1 | Transmitter idle |
| tdr_empty | output | 1 | Transmit holding empty |
| rdr_full | output | 1 | Receive register full |

## Verification
The bench drives cases where an event and a status read land in the same cycle. A design that lets the read win loses the event, and the flag reads 0 when 1 is expected. It also loads the receive register twice, once with and once without a read in between. A design with a wrong overrun condition either misses the overrun or flags it on a load that was read in the same cycle. It issues enable and disable together, and it writes and moves transmit data while disabled. A design with the wrong priority leaves the controller enabled or raises holding-empty while disabled. Finally it runs a transfer delay of three cycles and checks transmitter-idle at every cycle after the shifter goes idle. An off-by-one counter sets the flag one cycle early or late.

// File: rtl/sctl_status_pkg.sv
package sctl_status_pkg;
  localparam int unsigned SW_W       = 32;
  // bit positions the register decoder relies on
  localparam int unsigned BIT_EN     = 24;
  localparam int unsigned BIT_IEND   = 10;
  localparam int unsigned BIT_CSLVL  = 9;
  localparam int unsigned BIT_CSRISE = 8;
  localparam int unsigned BIT_OVR    = 3;
  localparam int unsigned BIT_TXIDLE = 2;
  localparam int unsigned BIT_THOLD  = 1;
  localparam int unsigned BIT_RFULL  = 0;

  localparam int unsigned N_STICKY   = 3;
  localparam int unsigned STK_IEND   = 0;
  localparam int unsigned STK_CSRISE = 1;
  localparam int unsigned STK_OVR    = 2;

  localparam logic [SW_W-1:0] SW_USED_MASK =
    (SW_W'(1) << BIT_EN)    | (SW_W'(1) << BIT_IEND)   |
    (SW_W'(1) << BIT_CSLVL) | (SW_W'(1) << BIT_CSRISE) |
    (SW_W'(1) << BIT_OVR)   | (SW_W'(1) << BIT_TXIDLE) |
    (SW_W'(1) << BIT_THOLD) | (SW_W'(1) << BIT_RFULL);
endpackage

// File: rtl/sctl_sticky.sv
module sctl_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  // set wins over a same-cycle clear
  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sctl_xfer_delay.sv
module sctl_xfer_delay #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             done_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             went_idle;
  logic             cnt_en;

  assign went_idle = busy_q & ~busy_i;
  assign cnt_en    = went_idle | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (went_idle)        cnt_d = dly_i;
    else if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
  end

  // delay has run out when the last count is being consumed this cycle
  always_comb begin
    if (busy_i)         done_o = 1'b0;
    else if (went_idle) done_o = (dly_i == '0);
    else                done_o = (cnt_q <= CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sctl_tx_track.sv
module sctl_tx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic disable_i,
  input  logic wr_i,
  input  logic move_i,
  input  logic idle_done_i,
  output logic en_o,
  output logic thold_o,
  output logic txidle_o
);
  logic en_q, en_d;
  logic thold_q, thold_d;
  logic txidle_q, txidle_d;

  always_comb begin
    en_d = en_q;
    if (enable_i)  en_d = 1'b1;
    if (disable_i) en_d = 1'b0;
  end

  always_comb begin
    thold_d = thold_q;
    if (!en_d)                  thold_d = 1'b0;
    else if (wr_i)              thold_d = 1'b0;
    else if (enable_i | move_i) thold_d = 1'b1;
  end

  always_comb begin
    txidle_d = txidle_q;
    if (wr_i)                         txidle_d = 1'b0;
    else if (thold_q && idle_done_i)  txidle_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      thold_q  <= 1'b0;
      txidle_q <= 1'b0;
    end else begin
      en_q     <= en_d;
      thold_q  <= thold_d;
      txidle_q <= txidle_d;
    end
  end

  assign en_o     = en_q;
  assign thold_o  = thold_q;
  assign txidle_o = txidle_q;
endmodule

// File: rtl/sctl_rx_track.sv
module sctl_rx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic rd_i,
  output logic full_o,
  output logic ovr_evt_o
);
  logic full_q, full_d;

  always_comb begin
    full_d = full_q;
    if (rd_i)   full_d = 1'b0;
    if (load_i) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  // unread data overwritten by a fresh load
  assign ovr_evt_o = load_i & full_q & ~rd_i;
  assign full_o    = full_q;
endmodule

// File: rtl/sctl_status.sv
module sctl_status
  import sctl_status_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_enable,
  input  logic             cmd_disable,
  input  logic             stat_rd,
  input  logic             tx_wr,
  input  logic             rx_rd,
  input  logic             tx_to_shift,
  input  logic             shift_busy,
  input  logic             rx_load,
  input  logic             instr_done,
  input  logic             cs_n,
  input  logic [DLY_W-1:0] xfer_dly,
  output logic [31:0]      status_word,
  output logic             en_sts,
  output logic             instr_end,
  output logic             cs_high,
  output logic             cs_rise,
  output logic             ovr_err,
  output logic             tx_empty,
  output logic             tdr_empty,
  output logic             rdr_full
);
  logic                cs_q;
  logic                idle_done;
  logic                ovr_evt;
  logic [N_STICKY-1:0] stk_set;
  logic [N_STICKY-1:0] stk_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b0;
    else        cs_q <= cs_n;
  end

  sctl_xfer_delay #(.CNT_W(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (shift_busy),
    .dly_i  (xfer_dly),
    .done_o (idle_done)
  );

  sctl_tx_track u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (cmd_enable),
    .disable_i   (cmd_disable),
    .wr_i        (tx_wr),
    .move_i      (tx_to_shift),
    .idle_done_i (idle_done),
    .en_o        (en_sts),
    .thold_o     (tdr_empty),
    .txidle_o    (tx_empty)
  );

  sctl_rx_track u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (rx_load),
    .rd_i      (rx_rd),
    .full_o    (rdr_full),
    .ovr_evt_o (ovr_evt)
  );

  assign stk_set[STK_IEND]   = instr_done;
  assign stk_set[STK_CSRISE] = cs_n & ~cs_q;
  assign stk_set[STK_OVR]    = ovr_evt;

  for (genvar g = 0; g < N_STICKY; g++) begin : g_stk
    sctl_sticky u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (stk_set[g]),
      .clr_i  (stat_rd),
      .flag_o (stk_flag[g])
    );
  end

  assign instr_end = stk_flag[STK_IEND];
  assign cs_rise   = stk_flag[STK_CSRISE];
  assign ovr_err   = stk_flag[STK_OVR];
  assign cs_high   = cs_q;

  always_comb begin
    status_word             = '0;
    status_word[BIT_EN]     = en_sts;
    status_word[BIT_IEND]   = instr_end;
    status_word[BIT_CSLVL]  = cs_high;
    status_word[BIT_CSRISE] = cs_rise;
    status_word[BIT_OVR]    = ovr_err;
    status_word[BIT_TXIDLE] = tx_empty;
    status_word[BIT_THOLD]  = tdr_empty;
    status_word[BIT_RFULL]  = rdr_full;
  end
endmodule

// File: rtl/sctl_status_chk.sv
module sctl_status_chk
  import sctl_status_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_enable,
  input logic        cmd_disable,
  input logic        stat_rd,
  input logic        tx_wr,
  input logic        rx_rd,
  input logic        rx_load,
  input logic        instr_done,
  input logic        cs_n,
  input logic [31:0] status_word,
  input logic        en_sts,
  input logic        instr_end,
  input logic        cs_high,
  input logic        ovr_err,
  input logic        tx_empty,
  input logic        tdr_empty,
  input logic        rdr_full
);
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~SW_USED_MASK) == '0);

  a_r3_iend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_end && !stat_rd) |=> instr_end);

  a_r3_iend_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> instr_end);

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !instr_done) |=> !instr_end);

  a_r4_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rdr_full && rx_load && !rx_rd) |=> ovr_err);

  a_r5_cs_level: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_high == $past(cs_n)));

  a_r6_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_disable |=> !en_sts);

  a_r7_off_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !en_sts |-> !tdr_empty);

  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> (!tx_empty && !tdr_empty));

  a_r9_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> rdr_full);
endmodule

bind sctl_status sctl_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_enable  (cmd_enable),
  .cmd_disable (cmd_disable),
  .stat_rd     (stat_rd),
  .tx_wr       (tx_wr),
  .rx_rd       (rx_rd),
  .rx_load     (rx_load),
  .instr_done  (instr_done),
  .cs_n        (cs_n),
  .status_word (status_word),
  .en_sts      (en_sts),
  .instr_end   (instr_end),
  .cs_high     (cs_high),
  .ovr_err     (ovr_err),
  .tx_empty    (tx_empty),
  .tdr_empty   (tdr_empty),
  .rdr_full    (rdr_full)
);

// File: tb/sctl_status_bench.sv
module sctl_status_bench;
  localparam int DLY_W = 8;
  localparam int NVEC  = 21;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_enable, cmd_disable, stat_rd, tx_wr, rx_rd;
  logic tx_to_shift, shift_busy, rx_load, instr_done, cs_n;
  logic [DLY_W-1:0] xfer_dly;
  logic [31:0] status_word;
  logic en_sts, instr_end, cs_high, cs_rise, ovr_err, tx_empty, tdr_empty, rdr_full;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sctl_status #(.DLY_W(DLY_W)) u_sctl_status (
    .clk(clk), .rst_n(rst_n), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .stat_rd(stat_rd), .tx_wr(tx_wr), .rx_rd(rx_rd), .tx_to_shift(tx_to_shift),
    .shift_busy(shift_busy), .rx_load(rx_load), .instr_done(instr_done),
    .cs_n(cs_n), .xfer_dly(xfer_dly), .status_word(status_word),
    .en_sts(en_sts), .instr_end(instr_end), .cs_high(cs_high), .cs_rise(cs_rise),
    .ovr_err(ovr_err), .tx_empty(tx_empty), .tdr_empty(tdr_empty), .rdr_full(rdr_full)
  );

  // stim {en,dis,srd,twr,rrd,mv,busy,load,ins,csn}
  // expected flags {en,iend,cslvl,csrise,ovr,txidle,thold,rfull}
  localparam logic [17:0] VEC [NVEC] = '{
    {10'b1000000000, 8'b1000_0010},  //  0 R6 R7 enable
    {10'b0000000000, 8'b1000_0110},  //  1 R8 idle sets
    {10'b0001000000, 8'b1000_0000},  //  2 R7 R8 write clears
    {10'b0000011000, 8'b1000_0010},  //  3 R7 move
    {10'b0000001000, 8'b1000_0010},  //  4 R8 busy holds
    {10'b0000000000, 8'b1000_0110},  //  5 R10 zero delay
    {10'b0000000100, 8'b1000_0111},  //  6 R9 load
    {10'b0000000100, 8'b1000_1111},  //  7 R4 second load
    {10'b0000100000, 8'b1000_1110},  //  8 R9 read clears
    {10'b0010000000, 8'b1000_0110},  //  9 R4 status read clears
    {10'b0000000001, 8'b1011_0110},  // 10 R3 R5 cs rises
    {10'b0010000001, 8'b1010_0110},  // 11 R3 read clears rise
    {10'b0000000010, 8'b1100_0110},  // 12 R3 R5 instr end, cs low
    {10'b0010000010, 8'b1100_0110},  // 13 R3 set wins over read
    {10'b0010000000, 8'b1000_0110},  // 14 R3 read clears
    {10'b0000100100, 8'b1000_0111},  // 15 R9 load wins over read
    {10'b0000100100, 8'b1000_0111},  // 16 R4 load with read, no overrun
    {10'b1100000000, 8'b0000_0101},  // 17 R6 disable wins
    {10'b0001000000, 8'b0000_0001},  // 18 R7 write while off
    {10'b0000010000, 8'b0000_0001},  // 19 R7 move while off
    {10'b0000100000, 8'b0000_0000}   // 20 R1 all clear
  };

  function automatic string row_req(int i);
    case (i)
      0, 17:          return "R6";
      2, 3, 18, 19:   return "R7";
      1, 4:           return "R8";
      5:              return "R10";
      6, 8, 15:       return "R9";
      7, 9, 16:       return "R4";
      10, 12:         return "R5";
      11, 13, 14:     return "R3";
      default:        return "R1";
    endcase
  endfunction

  function automatic logic [31:0] to_word(logic [7:0] f);
    logic [31:0] w = '0;
    w[24] = f[7]; w[10] = f[6]; w[9] = f[5]; w[8] = f[4];
    w[3]  = f[3]; w[2]  = f[2]; w[1] = f[1]; w[0] = f[0];
    return w;
  endfunction

  task automatic drive(logic [9:0] s);
    {cmd_enable, cmd_disable, stat_rd, tx_wr, rx_rd,
     tx_to_shift, shift_busy, rx_load, instr_done, cs_n} = s;
  endtask

  task automatic step(logic [9:0] s);
    drive(s);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_word(string req, logic [31:0] exp);
    logic [7:0] pins;
    pins = {en_sts, instr_end, cs_high, cs_rise, ovr_err, tx_empty, tdr_empty, rdr_full};
    checks++;
    if (status_word !== exp || to_word(pins) !== exp) begin
      errors++;
      $display("FAIL %s: word %h pins %b expected %h", req, status_word, pins, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive('0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    xfer_dly = '0;
    do_reset();
    check_word("R2", 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][17:8]);
      check_word(row_req(i), to_word(VEC[i][7:0]));
    end

    // R8: transfer delay of 3 cycles
    do_reset();
    xfer_dly = 8'd3;
    step(10'b1000000000);            // enable
    step(10'b0000000000);            // idle sets txidle
    check_bit("R8", tx_empty, 1'b1);
    step(10'b0001000000);            // write
    check_bit("R8", tx_empty, 1'b0);
    step(10'b0000011000);            // move + busy
    step(10'b0000001000);            // busy
    step(10'b0000000000);            // busy falls: edge N
    check_bit("R8", tx_empty, 1'b0);
    step(10'b0000000000);            // N+1
    check_bit("R8", tx_empty, 1'b0);
    step(10'b0000000000);            // N+2
    check_bit("R8", tx_empty, 1'b0);
    step(10'b0000000000);            // N+3
    check_bit("R8", tx_empty, 1'b1);

    // R2: asynchronous reset clears everything
    rst_n = 1'b0;
    #1;
    check_word("R2", 32'h0);
    rst_n = 1'b1;

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule